// File: doc/BRIEF.md
# Multi-Modulus Pulse-Swallow Feedback Divider

This block is a cycle-accurate digital model of the feedback divider in a fractional-N synthesizer. Seven divide-by-2/3 cells form a chain, and all of them run from the fast clock `clk`. A 7-bit modulus word sets the swallow bit of each cell, so one chain period lasts 128 plus the modulus, which gives 128 to 255 input clocks. The delta-sigma source that drives the modulus may change it once per output period. The block takes a new value only at the clock that closes a chain period, so the count that is already running is never disturbed.

Each cell is a small state machine with the states `PH_A` (first input tick), `PH_B` (second tick) and `PH_C` (the swallowed third tick). The transitions are `PH_A -> PH_B` on any input tick. `PH_B -> PH_C` happens on a tick when the cell swallows in this chain period and the cells above it are in their final cycle. `PH_B -> PH_A` happens on a tick otherwise, and the cell emits an output tick. `PH_C -> PH_A` happens on a tick, and the cell emits an output tick. The end-of-period event is passed through a staged retiming path. Its first flop is clocked by the third cell's output, its second by the second cell's output, and its last by the first cell's output. Because of this, the divided edge keeps the same distance from the period boundary for every modulus.

The same logic produces two timing enables. The bias-wake window lasts for the final cycle of cell 3, which is about one eighth of the period, and it closes ahead of the divided edge. The DAC window is four clocks wide and is centred on the divided rising edge.

Top module: `psd_divider`

## Requirements
- R1: While `rst_n` is low, `div_out`, `bias_en` and `dac_en` are low. The latched modulus resets to 0, so the first bias window after reset is 16 clocks long.
- R2: The number of `clk` cycles between two successive rising edges of `div_out` equals 128 plus the modulus latched for that interval. The modulus is unsigned, and bit i is the swallow control of cell i.
- R3: `mod_word` is sampled only at the clock that ends a chain period. A change at any other time leaves the interval in progress unchanged and takes effect for the following interval.
- R4: `div_out` stays high for exactly 8 clocks after each rising edge, and it is low at the chain period boundary.
- R5: `bias_en` stays high for 16 + (modulus mod 16) consecutive clocks once per interval. The modulus used is the one latched for the interval that ends at the next `div_out` rising edge.
- R6: `bias_en` falls 13 clocks before each `div_out` rising edge, so it is low when that edge occurs.
- R7: `dac_en` rises 2 clocks before each `div_out` rising edge and falls 2 clocks after it.
- R8: `bias_en` and `dac_en` are never high in the same cycle.
- R9: Every modulus from 0 to 127 gives the correct interval, including the extreme ratios 128 and 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_word | input | 7 | Modulus offset; the ratio is 128 + mod_word |
| div_out | output | 1 | Retimed divided output |
| bias_en | output | 1 | Charge-pump bias wake window |
| dac_en | output | 1 | Cancellation DAC pulse window |

## Verification
The bench steps through all 128 modulus values in a coprime order, so every swallow pattern is used at least once, including both extremes. A cell that swallows in the wrong cycle would change both the interval length and the bias window length. During every interval the bench writes a different value to the modulus input and later restores it. A design that latched the modulus in mid-period would show a wrong interval. The bench also measures each enable edge against the divided rising edge. A retiming stage that slipped, or a DAC window that started at the edge instead of straddling it, would show a wrong offset.

// File: rtl/psd_pkg.sv
package psd_pkg;
    parameter int PSD_CELLS = 7;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } cell_ph_e;
endpackage

// File: rtl/psd_cell.sv
module psd_cell
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic fin_in,
    input  logic swallow,
    output logic tick_out,
    output logic fin_out
);
    cell_ph_e ph_q;
    cell_ph_e ph_nxt;
    logic     last;
    logic     extend;

    assign extend = swallow & fin_in;

    // Next phase and end-of-cycle decode
    always_comb begin
        ph_nxt = ph_q;
        last   = 1'b0;
        unique case (ph_q)
            PH_A: ph_nxt = PH_B;
            PH_B: begin
                if (extend) begin
                    ph_nxt = PH_C;
                end else begin
                    ph_nxt = PH_A;
                    last   = 1'b1;
                end
            end
            PH_C: begin
                ph_nxt = PH_A;
                last   = 1'b1;
            end
            default: ph_nxt = PH_A;
        endcase
    end

    // Phase register advances only on an input tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_A;
        end else if (tick_in) begin
            ph_q <= ph_nxt;
        end
    end

    assign tick_out = tick_in & last;
    assign fin_out  = fin_in & last;
endmodule

// File: rtl/psd_resync.sv
module psd_resync (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic tk1,
    input  logic tk2,
    input  logic tk3,
    input  logic bias_win,
    output logic div_out,
    output logic bias_en,
    output logic dac_en
);
    logic pend_q;
    logic st3_q;
    logic st2_q;
    logic st1_q;
    logic bias_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            st3_q  <= 1'b0;
            st2_q  <= 1'b0;
            st1_q  <= 1'b0;
            bias_q <= 1'b0;
        end else begin
            if (wrap) begin
                pend_q <= 1'b1;
            end else if (tk3) begin
                pend_q <= 1'b0;
            end
            if (tk3) st3_q <= pend_q;
            if (tk2) st2_q <= st3_q;
            if (tk1) st1_q <= st2_q;
            bias_q <= bias_win;
        end
    end

    assign div_out = st1_q;
    assign bias_en = bias_q;
    assign dac_en  = st3_q & st2_q;
endmodule

// File: rtl/psd_divider.sv
module psd_divider
    import psd_pkg::*;
#(
    parameter int NCELL = PSD_CELLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCELL-1:0] mod_word,
    output logic             div_out,
    output logic             bias_en,
    output logic             dac_en
);
    localparam int BIAS_IDX = NCELL - 3;

    logic [NCELL:0]   tk;
    logic [NCELL:0]   fin;
    logic [NCELL-1:0] mod_q;
    logic             wrap;

    assign tk[0]      = 1'b1;
    assign fin[NCELL] = 1'b1;
    assign wrap       = tk[NCELL];

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        psd_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_in  (tk[i]),
            .fin_in   (fin[i+1]),
            .swallow  (mod_q[i]),
            .tick_out (tk[i+1]),
            .fin_out  (fin[i])
        );
    end

    // Modulus is taken only at the last clock of a chain period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= '0;
        end else if (fin[0]) begin
            mod_q <= mod_word;
        end
    end

    psd_resync u_resync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .tk1      (tk[1]),
        .tk2      (tk[2]),
        .tk3      (tk[3]),
        .bias_win (fin[BIAS_IDX]),
        .div_out  (div_out),
        .bias_en  (bias_en),
        .dac_en   (dac_en)
    );
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
    parameter int NCELL = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wrap,
    input logic [NCELL-1:0] mod_word,
    input logic [NCELL-1:0] mod_q,
    input logic             div_out,
    input logic             bias_en,
    input logic             dac_en
);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mod_q));

    a_r3_take: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (mod_q == $past(mod_word)));

    a_r4_wrap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (!div_out && !dac_en));

    a_r6_bias_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> !bias_en);

    a_r7_dac_span: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> dac_en);

    a_r8_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !(bias_en && dac_en));
endmodule

bind psd_divider psd_divider_chk #(.NCELL(NCELL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap),
    .mod_word (mod_word),
    .mod_q    (mod_q),
    .div_out  (div_out),
    .bias_en  (bias_en),
    .dac_en   (dac_en)
);

// File: tb/psd_divider_tb.sv
module psd_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] mod_word;
    logic       div_out;
    logic       bias_en;
    logic       dac_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    psd_divider u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_word (mod_word),
        .div_out  (div_out),
        .bias_en  (bias_en),
        .dac_en   (dac_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int seq_val(input int k);
        return (k * 37 + 5) % 128;
    endfunction

    initial begin
        int cyc = 0;
        int nrise = 0;
        int last_rise = 0;
        int bias_on = 0;
        int bias_w = -1;
        int bias_fall = 0;
        int dac_on = 0;
        int overlap = 0;
        int cur_l = 0;
        int pend = 0;
        int init_val = 90;
        bit p_div = 1'b0;
        bit p_bias = 1'b0;
        bit p_dac = 1'b0;

        rst_n    = 1'b0;
        mod_word = 7'(init_val);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!div_out && !bias_en && !dac_en, "R1 outputs low in reset",
                  {29'd0, div_out, bias_en, dac_en}, 0);
        end
        rst_n = 1'b1;

        while (nrise < 132 && cyc < 60000) begin
            @(negedge clk);
            cyc++;
            if (bias_en && dac_en) overlap++;
            if (bias_en && !p_bias) bias_on = cyc;
            if (!bias_en && p_bias) begin
                bias_w    = cyc - bias_on;
                bias_fall = cyc;
            end
            if (dac_en && !p_dac) dac_on = cyc;
            if (!dac_en && p_dac) check(cyc - last_rise == 2, "R7 dac falls after edge", cyc - last_rise, 2);
            if (!div_out && p_div) check(cyc - last_rise == 8, "R4 high width", cyc - last_rise, 8);
            if (div_out && !p_div) begin
                if (nrise == 0) begin
                    check(bias_w == 16, "R1 reset modulus zero", bias_w, 16);
                    cur_l = init_val;
                end else begin
                    if (cur_l == 0 || cur_l == 127)
                        check(cyc - last_rise == 128 + cur_l, "R9 extreme ratio", cyc - last_rise, 128 + cur_l);
                    else
                        check(cyc - last_rise == 128 + cur_l, "R2 R3 interval", cyc - last_rise, 128 + cur_l);
                    check(bias_w == 16 + (cur_l % 16), "R5 bias width", bias_w, 16 + (cur_l % 16));
                    cur_l = pend;
                end
                check(cyc - bias_fall == 13, "R6 bias lead", cyc - bias_fall, 13);
                check(cyc - dac_on == 2, "R7 dac lead", cyc - dac_on, 2);
                pend      = seq_val(nrise);
                mod_word  = 7'(pend);
                last_rise = cyc;
                nrise++;
            end
            // R3: disturb the modulus mid-period, then restore it
            if (nrise > 0 && cyc == last_rise + 30) mod_word = ~7'(pend);
            if (nrise > 0 && cyc == last_rise + 60) mod_word = 7'(pend);
            p_div  = div_out;
            p_bias = bias_en;
            p_dac  = dac_en;
        end

        check(nrise >= 132, "watchdog rising edges", nrise, 132);
        check(overlap == 0, "R8 enables disjoint", overlap, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule